// File: doc/BRIEF.md
# Two-Dimensional DMA Row Address Generator

This block turns one queued transfer request into a stream of row burst commands for a DMA engine. A request describes a rectangle: a source base, a destination base, the bytes in each row, the number of rows, and a separate row pitch for each side. The generator emits one command per row. Each command carries the start address of the row on each side and the row's byte count. Commands leave on a valid/ready handshake. The bus engine and the data buffer that consume the commands are outside this block.

At build time each side is set up either as memory or as a fixed peripheral stream. A memory side starts at its base and moves forward by its own pitch after every row. A stream side has no address and always shows zero. If a request is marked for repeat, the generator goes back to the original bases once the last row has gone out and starts the same rectangle again. It keeps doing this until the halt input stops it. A one-cycle completion pulse carries the request's identifier at the end of every pass.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `cmd_valid` and `done_valid` are low, and `req_ready` is high while `halt` is low.
- R2: `req_x_len` and `req_y_len` are coded as count minus one. Every command of a request has `cmd_bytes` equal to `req_x_len + 1`, so a code of 0 gives a 1-byte row.
- R3: A request produces exactly `req_y_len + 1` accepted commands per pass. A code of 0 gives a single row.
- R4: On a memory side, the k-th row of a pass (k counted from 0) starts at base + k × pitch on that side. The pitch may be larger than the row length, which leaves a gap between rows.
- R5: With the default build the source side is memory and the destination side is a stream. A stream side always drives address 0, whatever base and pitch are requested.
- R6: For a non-repeat request, `done_valid` is high for exactly one cycle, carrying `req_id` on `done_id`. This happens in the cycle after the last row command is accepted. `req_ready` is high again in that same cycle.
- R7: When `req_cyclic` is 1, the command that follows the last row starts again at the original bases. `done_valid` pulses with the identifier at the end of every pass.
- R8: While `halt` is high, `req_ready` is low. A halt during a transfer takes effect at the next accepted row: that row goes out, and then `cmd_valid` falls. No completion is signalled unless that row was the last row of a pass.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_src_addr`, `cmd_dst_addr` and `cmd_bytes` stay unchanged.
- R10: The low log2(`ALIGN_BYTES`) bits of every emitted address are zero. Bases and pitches are assumed to be aligned to `ALIGN_BYTES`.
- R11: While a transfer is running, `req_ready` is low, and a request presented on the request inputs has no effect on the commands of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Stop at the next row boundary; blocks new requests |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_id | input | ID_W | Transfer identifier |
| req_cyclic | input | 1 | Repeat the rectangle until halted |
| req_src_base | input | ADDR_W | Source start address |
| req_src_stride | input | ADDR_W | Source row pitch in bytes |
| req_dst_base | input | ADDR_W | Destination start address |
| req_dst_stride | input | ADDR_W | Destination row pitch in bytes |
| req_x_len | input | LEN_W | Bytes per row minus one |
| req_y_len | input | LEN_W | Rows minus one |
| cmd_valid | output | 1 | Row command offered |
| cmd_ready | input | 1 | Row command taken |
| cmd_src_addr | output | ADDR_W | Source start of the current row |
| cmd_dst_addr | output | ADDR_W | Destination start of the current row |
| cmd_bytes | output | LEN_W+1 | Bytes in the current row |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | ID_W | Identifier of the completed transfer |

## Verification
A row counter stuck at the wrong value shows up within one pass. The completion pulse then comes one command too early or too late, and that command's address breaks the base + k × pitch pattern. A fault in the pitch adder shows up one command after the first row. A bad repeat reload shows up on the first command of the second pass, which then fails to come back to the base. A fault in the control state shows up as a command seen while `req_ready` is high, as a missing completion pulse, or as commands that keep coming after a halt. In every one of these cases the fault is visible on the first handshake that depends on the broken state.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/dma2d_walker.sv
// Per-side row address walker. A memory side keeps its base and pitch,
// steps by the pitch per row and reloads the base for a repeat pass.
// A stream side drives zero.
module dma2d_walker #(
   parameter int ADDR_W      = 32,
   parameter bit IS_MEM      = 1'b1,
   parameter int ALIGN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              reload,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(ALIGN_BYTES - 1));

   if (IS_MEM) begin : g_mem
      logic [ADDR_W-1:0] base_q;
      logic [ADDR_W-1:0] stride_q;
      logic [ADDR_W-1:0] addr_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            addr_q   <= '0;
         end else if (load) begin
            base_q   <= base & KEEP_MASK;
            stride_q <= stride & KEEP_MASK;
            addr_q   <= base & KEEP_MASK;
         end else if (reload) begin
            addr_q   <= base_q;
         end else if (step) begin
            addr_q   <= addr_q + stride_q;
         end
      end

      assign addr = addr_q;
   end else begin : g_stream
      logic unused_stream_inputs;
      assign unused_stream_inputs = ^{clk, rst_n, load, step, reload, base, stride};
      assign addr = '0;
   end
endmodule

// File: rtl/dma2d_rows.sv
// Row counter and row byte count for one request.
module dma2d_rows #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             reload,
   input  logic [LEN_W-1:0] x_code,
   input  logic [LEN_W-1:0] y_code,
   output logic             last_row,
   output logic [LEN_W:0]   row_bytes
);
   logic [LEN_W-1:0] y_lim_q;
   logic [LEN_W-1:0] row_q;
   logic [LEN_W:0]   bytes_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_lim_q <= '0;
         row_q   <= '0;
         bytes_q <= '0;
      end else if (load) begin
         y_lim_q <= y_code;
         row_q   <= '0;
         bytes_q <= {1'b0, x_code} + (LEN_W+1)'(1);
      end else if (reload) begin
         row_q   <= '0;
      end else if (step) begin
         row_q   <= row_q + LEN_W'(1);
      end
   end

   assign last_row  = (row_q == y_lim_q);
   assign row_bytes = bytes_q;

   // R3: the row index never passes the programmed row limit
   a_r3_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= y_lim_q);
endmodule

// File: rtl/dma2d_seq.sv
// Sequencer: takes requests, hands out row commands, decides between next
// row, repeat pass, or idle, and produces the completion pulse.
module dma2d_seq
   import dma2d_pkg::*;
#(
   parameter int ID_W      = 4,
   parameter bit CYCLIC_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   input  logic            req_cyclic,
   input  logic            cmd_ready,
   input  logic            last_row,
   output logic            req_ready,
   output logic            cmd_valid,
   output logic            load,
   output logic            step,
   output logic            reload,
   output logic            done_valid,
   output logic [ID_W-1:0] done_id
);
   seq_state_e      state_q, state_d;
   logic            cyclic_q;
   logic [ID_W-1:0] id_q;
   logic            done_q;
   logic [ID_W-1:0] done_id_q;
   logic            fire;
   logic            end_pass;
   logic            keep_going;

   assign req_ready  = (state_q == SEQ_IDLE) && !halt;
   assign cmd_valid  = (state_q == SEQ_RUN);
   assign load       = req_valid && req_ready;
   assign fire       = cmd_valid && cmd_ready;
   assign end_pass   = fire && last_row;
   assign keep_going = cyclic_q && !halt;
   assign step       = fire && !last_row && !halt;
   assign reload     = end_pass && keep_going;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (load) state_d = SEQ_RUN;
         SEQ_RUN:  if (fire && (halt || (last_row && !keep_going))) state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         cyclic_q  <= 1'b0;
         id_q      <= '0;
         done_q    <= 1'b0;
         done_id_q <= '0;
      end else begin
         state_q <= state_d;
         if (load) begin
            cyclic_q <= req_cyclic && CYCLIC_EN;
            id_q     <= req_id;
         end
         done_q    <= end_pass;
         done_id_q <= id_q;
      end
   end

   assign done_valid = done_q;
   assign done_id    = done_id_q;

   // R8: a halted boundary ends the command stream
   a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && halt) |=> !cmd_valid);

   // R6: a completion pulse only follows an accepted command
   a_r6_done_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(fire));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 12,
   parameter int ID_W        = 4,
   parameter bit SRC_IS_MEM  = 1'b1,
   parameter bit DST_IS_MEM  = 1'b0,
   parameter int ALIGN_BYTES = 4,
   parameter bit CYCLIC_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_cyclic,
   input  logic [ADDR_W-1:0] req_src_base,
   input  logic [ADDR_W-1:0] req_src_stride,
   input  logic [ADDR_W-1:0] req_dst_base,
   input  logic [ADDR_W-1:0] req_dst_stride,
   input  logic [LEN_W-1:0]  req_x_len,
   input  logic [LEN_W-1:0]  req_y_len,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_src_addr,
   output logic [ADDR_W-1:0] cmd_dst_addr,
   output logic [LEN_W:0]    cmd_bytes,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id
);
   if (ALIGN_BYTES < 1 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
      $error("ALIGN_BYTES must be a power of two");
   end
   if (ADDR_W < 8 || LEN_W < 1 || ID_W < 1) begin : g_bad_width
      $error("ADDR_W, LEN_W and ID_W out of range");
   end

   logic load, step, reload, last_row;

   dma2d_seq #(.ID_W(ID_W), .CYCLIC_EN(CYCLIC_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .req_valid(req_valid), .req_id(req_id), .req_cyclic(req_cyclic),
      .cmd_ready(cmd_ready), .last_row(last_row),
      .req_ready(req_ready), .cmd_valid(cmd_valid),
      .load(load), .step(step), .reload(reload),
      .done_valid(done_valid), .done_id(done_id)
   );

   dma2d_rows #(.LEN_W(LEN_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .reload(reload),
      .x_code(req_x_len), .y_code(req_y_len),
      .last_row(last_row), .row_bytes(cmd_bytes)
   );

   dma2d_walker #(.ADDR_W(ADDR_W), .IS_MEM(SRC_IS_MEM), .ALIGN_BYTES(ALIGN_BYTES)) u_src (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .reload(reload),
      .base(req_src_base), .stride(req_src_stride), .addr(cmd_src_addr)
   );

   dma2d_walker #(.ADDR_W(ADDR_W), .IS_MEM(DST_IS_MEM), .ALIGN_BYTES(ALIGN_BYTES)) u_dst (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .reload(reload),
      .base(req_dst_base), .stride(req_dst_stride), .addr(cmd_dst_addr)
   );

   // R9: an offered command is held until taken
   a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src_addr)
                                     && $stable(cmd_dst_addr) && $stable(cmd_bytes)));

   // R11: no new request is taken while commands are being offered
   a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid);
endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_id = '0;
   logic        req_cyclic = 1'b0;
   logic [31:0] req_src_base = '0, req_src_stride = '0;
   logic [31:0] req_dst_base = '0, req_dst_stride = '0;
   logic [11:0] req_x_len = '0, req_y_len = '0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [31:0] cmd_src_addr, cmd_dst_addr;
   logic [12:0] cmd_bytes;
   logic        done_valid;
   logic [3:0]  done_id;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma2d_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
      .req_cyclic(req_cyclic),
      .req_src_base(req_src_base), .req_src_stride(req_src_stride),
      .req_dst_base(req_dst_base), .req_dst_stride(req_dst_stride),
      .req_x_len(req_x_len), .req_y_len(req_y_len),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
      .cmd_bytes(cmd_bytes), .done_valid(done_valid), .done_id(done_id)
   );

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   // records of accepted commands and completion pulses
   logic [31:0] r_src [0:63];
   logic [31:0] r_dst [0:63];
   logic [12:0] r_bytes [0:63];
   logic [3:0]  d_id [0:63];
   int n_rows = 0;
   int n_done = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst_n && cmd_valid && cmd_ready) begin
         if (n_rows < 64) begin
            r_src[n_rows]   <= cmd_src_addr;
            r_dst[n_rows]   <= cmd_dst_addr;
            r_bytes[n_rows] <= cmd_bytes;
         end
         n_rows <= n_rows + 1;
      end
      if (rst_n && done_valid) begin
         if (n_done < 64) d_id[n_done] <= done_id;
         n_done <= n_done + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      @(negedge clk);
      n_rows = 0;
      n_done = 0;
   endtask

   task automatic offer(input logic [3:0] id, input logic [31:0] sb, input logic [31:0] ss,
                        input logic [11:0] x, input logic [11:0] y, input bit cyc);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_id = id; req_src_base = sb; req_src_stride = ss;
      req_dst_base = 32'h8000_0040; req_dst_stride = 32'h100;
      req_x_len = x; req_y_len = y; req_cyclic = cyc;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // toggle: 0 = always ready, 1 = ready every other cycle
   task automatic run_until(input int want_done, input bit toggle);
      int guard = 0;
      while (n_done < want_done && guard < 2000) begin
         cmd_ready = toggle ? ~cmd_ready : 1'b1;
         @(negedge clk);
         guard++;
      end
      cmd_ready = 1'b0;
   endtask

   task automatic check_rows(input string tag, input logic [31:0] sb, input logic [31:0] ss,
                             input int rows_per_pass, input int nr, input logic [12:0] bytes);
      for (int k = 0; k < nr && k < 64; k++) begin
         logic [31:0] ea;
         ea = sb + 32'(k % rows_per_pass) * ss;
         chk(r_src[k] == ea, {tag, " R4 src addr"}, r_src[k], ea);
         chk(r_dst[k] == 32'h0, {tag, " R5 dst stream"}, r_dst[k], 0);
         chk(r_bytes[k] == bytes, {tag, " R2 bytes"}, r_bytes[k], bytes);
         chk(r_src[k][1:0] == 2'b00, {tag, " R10 align"}, r_src[k][1:0], 0);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
      chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
      chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
   endtask

   task automatic t_gap_rows();
      clear_log();
      offer(4'h3, 32'h0000_1000, 32'h40, 12'd7, 12'd3, 1'b0);
      run_until(1, 1'b0);
      @(negedge clk);
      chk(n_rows == 4, "R3 row count", n_rows, 4);
      check_rows("gap", 32'h1000, 32'h40, 4, 4, 13'd8);
      chk(n_done == 1, "R6 one done", n_done, 1);
      chk(d_id[0] == 4'h3, "R6 done id", d_id[0], 3);
      chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R6 back idle", {req_ready, cmd_valid}, 2);
   endtask

   task automatic t_done_timing();
      // R6: pulse exactly the cycle after the last accept, ready again then
      clear_log();
      offer(4'h9, 32'h0000_2000, 32'h10, 12'd15, 12'd1, 1'b0);
      cmd_ready = 1'b1;
      @(negedge clk);
      chk(done_valid == 1'b0, "R6 no early done", done_valid, 0);
      @(negedge clk);
      chk(done_valid == 1'b1 && done_id == 4'h9, "R6 done pulse", {done_valid, done_id}, 5'h19);
      chk(req_ready == 1'b1, "R6 ready with done", req_ready, 1);
      cmd_ready = 1'b0;
      @(negedge clk);
      chk(done_valid == 1'b0, "R6 single cycle", done_valid, 0);
      check_rows("dt", 32'h2000, 32'h10, 2, 2, 13'd16);
   endtask

   task automatic t_backpressure();
      clear_log();
      offer(4'h5, 32'h0000_3000, 32'h10, 12'd15, 12'd2, 1'b0);
      run_until(1, 1'b1);
      @(negedge clk);
      chk(n_rows == 3, "R3 rows under stall", n_rows, 3);
      check_rows("bp", 32'h3000, 32'h10, 3, 3, 13'd16);
      chk(d_id[0] == 4'h5, "R6 id under stall", d_id[0], 5);
   endtask

   task automatic t_single_row();
      clear_log();
      offer(4'h1, 32'h0000_4444, 32'h8, 12'd3, 12'd0, 1'b0);
      run_until(1, 1'b0);
      @(negedge clk);
      chk(n_rows == 1, "R3 single row", n_rows, 1);
      check_rows("one", 32'h4444, 32'h8, 1, 1, 13'd4);
   endtask

   task automatic t_busy_ignore();
      clear_log();
      offer(4'h6, 32'h0000_5000, 32'h20, 12'd7, 12'd1, 1'b0);
      // stalled: present another request
      req_id = 4'hE; req_src_base = 32'h0009_0000; req_src_stride = 32'h4;
      req_x_len = 12'd3; req_y_len = 12'd9; req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R11 ready low busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
      run_until(1, 1'b0);
      @(negedge clk);
      chk(n_rows == 2, "R11 rows of first", n_rows, 2);
      check_rows("busy", 32'h5000, 32'h20, 2, 2, 13'd8);
      chk(d_id[0] == 4'h6, "R11 id of first", d_id[0], 6);
   endtask

   task automatic t_cyclic();
      clear_log();
      offer(4'hA, 32'h0000_6000, 32'h80, 12'd31, 12'd1, 1'b1);
      run_until(3, 1'b0);
      chk(n_rows >= 6, "R7 rows over passes", n_rows, 6);
      check_rows("cyc", 32'h6000, 32'h80, 2, 6, 13'd32);
      chk(d_id[0] == 4'hA && d_id[2] == 4'hA, "R7 done ids", d_id[2], 4'hA);
      chk(cmd_valid == 1'b1, "R7 still running", cmd_valid, 1);
      halt = 1'b1;
      chk(req_ready == 1'b0, "R8 ready low halted", req_ready, 0);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R8 cyclic halted", cmd_valid, 0);
      halt = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_halt();
      clear_log();
      offer(4'h7, 32'h0000_7000, 32'h40, 12'd7, 12'd5, 1'b0);
      halt = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 ready blocked", req_ready, 0);
      chk(cmd_valid == 1'b1, "R8 held until boundary", cmd_valid, 1);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R8 stopped", cmd_valid, 0);
      chk(n_rows == 1, "R8 one row out", n_rows, 1);
      chk(n_done == 0, "R8 no done", n_done, 0);
      chk(r_src[0] == 32'h7000, "R8 row addr", r_src[0], 32'h7000);
      halt = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready after release", req_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gap_rows();
      t_done_timing();
      t_backpressure();
      t_single_row();
      t_busy_ignore();
      t_cyclic();
      t_halt();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule